// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block gives several requesters a shared word memory with load-exclusive and store-exclusive operations, alongside ordinary loads and stores. A load-exclusive returns the addressed word. It also records a reservation for that requester on the line that holds the word. A line is a parameterised group of consecutive words. A later store-exclusive from the same requester commits only if that reservation has survived. It reports a status bit: 0 when the write was made, 1 when it was refused.

A reservation is lost in four ways. Another requester may write anywhere in the line, even to a different word. A successful store-exclusive from another requester may hit the line. A per-requester clear input, raised for an interrupt or a context switch, also removes it. Last, any store-exclusive from the owner removes it, whether or not the store succeeds. A store-exclusive can therefore fail while the stored value is still what the caller expected. The caller must then issue a new load-exclusive before it tries again.

Requests are held on per-requester valid lines. A fixed-priority arbiter grants one of them per cycle, and the lowest index wins. The response for a granted request appears on the cycle after the grant. It carries the requester index, the read data and the status.

Top module: `excl_monitor`

## Requirements
- R1: Reset leaves `resp_valid` low and clears every reservation, so a store-exclusive issued after reset with no new load-exclusive returns status 1.
- R2: When any `req_valid` bit is set, exactly one `grant` bit is set: the lowest-indexed valid requester. `grant` is never set for a requester without `req_valid`.
- R3: A load (op 2'b00) or load-exclusive (op 2'b10) returns the addressed word on `resp_rdata`. A load-exclusive also reserves the line `addr >> log2(LINE_WORDS)` for the issuing requester.
- R4: Every grant produces exactly one response on the next cycle, carrying the granted index on `resp_id`. A store-exclusive (op 2'b11) whose requester holds a reservation on the target line writes memory and returns status 0.
- R5: A store-exclusive to a line other than the reserved one returns status 1 and leaves memory unchanged. Only a store-exclusive can return status 1. Plain stores (op 2'b01) always write and return status 0.
- R6: A plain store by another requester to any word of a reserved line cancels that reservation. A store to a different line does not.
- R7: A pulse on `rsv_clear[i]` cancels requester i's reservation, and its next store-exclusive fails even when the data is unchanged.
- R8: A store-exclusive always cancels its own requester's reservation, so a second store-exclusive with no load-exclusive between them fails.
- R9: A successful store-exclusive cancels the reservations of other requesters on the same line.
- R10: A new load-exclusive replaces the requester's previous reservation, and the old line is no longer reserved.
- R11: When `rsv_clear[i]` is raised in the cycle requester i's store-exclusive is granted, the store fails. When it is raised with a granted load-exclusive, the new reservation is kept.
- R12: A requester's own plain store into its reserved line does not cancel its reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request pending, one bit per requester |
| req_op | input | 2*N | Operation per requester: 00 load, 01 store, 10 load-exclusive, 11 store-exclusive |
| req_addr | input | N*AW | Word address per requester |
| req_wdata | input | N*DW | Write data per requester |
| rsv_clear | input | N | Event clear of a requester's reservation |
| grant | output | N | Request accepted this cycle (one-hot or zero) |
| resp_valid | output | 1 | Response present |
| resp_id | output | IW | Index of the responding requester |
| resp_rdata | output | DW | Word read for a load or load-exclusive |
| resp_status | output | 1 | 1 when a store-exclusive was refused, else 0 |

## Verification
Two functions can land in one cycle: an event clear and a granted exclusive operation of the same requester. The bench raises `rsv_clear` in the same cycle that it drives the store-exclusive or load-exclusive. It then judges the result in two ways: from the status of that store, and from whether a following store-exclusive succeeds. Arbitration collisions are also provoked, by raising two requests in one cycle. The grant order is then confirmed both at `grant` and through the order of the responses in the scoreboard.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_LDX = 2'b10,
    OP_STX = 2'b11
  } xop_e;
endpackage

// File: rtl/xmon_arb.sv
module xmon_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xmon_rsv.sv
module xmon_rsv
  import xmon_pkg::*;
#(
  parameter int N    = 4,
  parameter int AW   = 6,
  parameter int LOFF = 2,
  localparam int TW  = AW - LOFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  gnt,
  input  xop_e          sel_op,
  input  logic [AW-1:0] sel_addr,
  input  logic [N-1:0]  clear,
  output logic          stx_ok
);
  logic [TW-1:0] line;
  logic [N-1:0]  v_q, v_d;
  logic [N-1:0]  own_hit;
  logic          any_gnt;
  logic          line_write;

  assign line    = sel_addr[AW-1:LOFF];
  assign any_gnt = |gnt;
  assign stx_ok  = any_gnt && (sel_op == OP_STX) && |(gnt & own_hit & ~clear);
  assign line_write = any_gnt && ((sel_op == OP_ST) || ((sel_op == OP_STX) && stx_ok));

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [TW-1:0] tag_q;
    logic          tag_en;

    assign own_hit[i] = v_q[i] && (tag_q == line);
    assign tag_en     = gnt[i] && (sel_op == OP_LDX);

    always_comb begin
      v_d[i] = v_q[i];
      if (gnt[i] && (sel_op == OP_LDX))      v_d[i] = 1'b1;
      else if (gnt[i] && (sel_op == OP_STX)) v_d[i] = 1'b0;
      else if (clear[i])                     v_d[i] = 1'b0;
      else if (!gnt[i] && line_write && own_hit[i]) v_d[i] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (tag_en) tag_q <= line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end
endmodule

// File: rtl/xmon_mem.sv
module xmon_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import xmon_pkg::*;
#(
  parameter int N          = 4,
  parameter int DW         = 32,
  parameter int DEPTH      = 64,
  parameter int LINE_WORDS = 4,
  localparam int AW        = $clog2(DEPTH),
  localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_op,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  input  logic [N-1:0]    rsv_clear,
  output logic [N-1:0]    grant,
  output logic            resp_valid,
  output logic [IW-1:0]   resp_id,
  output logic [DW-1:0]   resp_rdata,
  output logic            resp_status
);
  localparam int LOFF = $clog2(LINE_WORDS);

  xop_e          sel_op;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_wdata;
  logic [IW-1:0] sel_id;
  logic          any_gnt;
  logic          stx_ok;
  logic          mem_we;
  logic          status_d;

  xmon_arb #(.N(N)) u_arb (
    .req (req_valid),
    .gnt (grant)
  );

  always_comb begin
    sel_op    = OP_LD;
    sel_addr  = '0;
    sel_wdata = '0;
    sel_id    = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        sel_op    = xop_e'(req_op[2*i +: 2]);
        sel_addr  = req_addr[i*AW +: AW];
        sel_wdata = req_wdata[i*DW +: DW];
        sel_id    = IW'(i);
      end
    end
  end

  assign any_gnt = |grant;

  xmon_rsv #(.N(N), .AW(AW), .LOFF(LOFF)) u_rsv (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (grant),
    .sel_op   (sel_op),
    .sel_addr (sel_addr),
    .clear    (rsv_clear),
    .stx_ok   (stx_ok)
  );

  assign mem_we   = any_gnt && ((sel_op == OP_ST) || ((sel_op == OP_STX) && stx_ok));
  assign status_d = (sel_op == OP_STX) && !stx_ok;

  xmon_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .re    (any_gnt),
    .we    (mem_we),
    .addr  (sel_addr),
    .wdata (sel_wdata),
    .rdata (resp_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= any_gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_id     <= '0;
      resp_status <= 1'b0;
    end else if (any_gnt) begin
      resp_id     <= sel_id;
      resp_status <= status_d;
    end
  end
endmodule

// File: rtl/xmon_chk.sv
module xmon_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req_valid,
  input logic [2*N-1:0] req_op,
  input logic [N-1:0]   rsv_clear,
  input logic [N-1:0]   grant,
  input logic           resp_valid,
  input logic           resp_status
);
  logic g_stx;
  logic g_stx_clr;

  always_comb begin
    g_stx     = 1'b0;
    g_stx_clr = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (grant[i] && (req_op[2*i +: 2] == 2'b11)) begin
        g_stx     = 1'b1;
        g_stx_clr = rsv_clear[i];
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0); // R2
  AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |-> (|grant)); // R2
  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (((grant - 1'b1) & req_valid) == '0)); // R2
  AST_RESP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> resp_valid); // R4
  AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grant) |=> !resp_valid); // R4
  AST_FAIL_ONLY_STX: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status) |-> $past(g_stx)); // R5
  AST_CLEAR_BEATS_STX: assert property (@(posedge clk) disable iff (!rst_n)
    g_stx_clr |=> (resp_valid && resp_status)); // R11
endmodule

bind excl_monitor xmon_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .rsv_clear   (rsv_clear),
  .grant       (grant),
  .resp_valid  (resp_valid),
  .resp_status (resp_status)
);

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int IW = 2;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LDX = 2'b10, STX = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    rsv_clear = '0;
  logic [N-1:0]    grant;
  logic            resp_valid;
  logic [IW-1:0]   resp_id;
  logic [DW-1:0]   resp_rdata;
  logic            resp_status;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    int          id;
    bit          chk_data;
    logic [31:0] data;
    logic        status;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  excl_monitor #(.N(N), .DW(DW), .DEPTH(DEPTH), .LINE_WORDS(4)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsv_clear(rsv_clear),
    .grant(grant), .resp_valid(resp_valid), .resp_id(resp_id),
    .resp_rdata(resp_rdata), .resp_status(resp_status)
  );

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n === 1'b1 && resp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected response", 32'(resp_id), 32'hFFFF);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(resp_id == IW'(e.id), e.tag, "resp_id", 32'(resp_id), 32'(e.id));
        check(resp_status == e.status, e.tag, "resp_status", 32'(resp_status), 32'(e.status));
        if (e.chk_data)
          check(resp_rdata == e.data, e.tag, "resp_rdata", resp_rdata, e.data);
      end
    end
  end

  task automatic set_req(int id, logic [1:0] op, int addr, logic [31:0] wd);
    req_valid[id] = 1'b1;
    req_op[2*id +: 2] = op;
    req_addr[id*AW +: AW] = AW'(addr);
    req_wdata[id*DW +: DW] = wd;
  endtask

  // starts and ends just after a falling edge
  task automatic issue(int id, logic [1:0] op, int addr, logic [31:0] wd,
                       bit chk, logic [31:0] edata, logic estat, string tag, bit clr = 0);
    exp_t e;
    set_req(id, op, addr, wd);
    if (clr) rsv_clear[id] = 1'b1;
    #1;
    while (!grant[id]) begin
      @(negedge clk);
      #1;
    end
    e.id = id; e.chk_data = chk; e.data = edata; e.status = estat; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid[id] = 1'b0;
    rsv_clear[id] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 32'(exp_q.size()), 32'h0);
    report();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grant == '0, "R2", "idle grant", 32'(grant), 0);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 0);

    // preload
    issue(0, ST, 8,  32'hA0, 0, 0, 0, "R5");
    issue(0, ST, 9,  32'hA1, 0, 0, 0, "R5");
    issue(0, ST, 20, 32'hB0, 0, 0, 0, "R5");
    issue(0, ST, 12, 32'h12, 0, 0, 0, "R5");
    // R1: no reservation after reset
    issue(1, STX, 8, 32'h55, 0, 0, 1, "R1");
    issue(0, LD, 8, 0, 1, 32'hA0, 0, "R5");
    // R3/R4: reserve and commit in the same line
    issue(1, LDX, 8, 0, 1, 32'hA0, 0, "R3");
    issue(1, STX, 9, 32'hC1, 0, 0, 0, "R4");
    issue(2, LD, 9, 0, 1, 32'hC1, 0, "R4");
    // R8: reservation consumed
    issue(1, STX, 9, 32'hEE, 0, 0, 1, "R8");
    // R5: other line fails, memory unchanged; failed store also consumes
    issue(1, LDX, 8, 0, 1, 32'hA0, 0, "R3");
    issue(1, STX, 20, 32'h77, 0, 0, 1, "R5");
    issue(3, LD, 20, 0, 1, 32'hB0, 0, "R5");
    issue(1, STX, 8, 32'h78, 0, 0, 1, "R8");
    // R6: store to other line keeps the reservation
    issue(2, LDX, 12, 0, 1, 32'h12, 0, "R3");
    issue(0, ST, 16, 32'h16, 0, 0, 0, "R6");
    issue(2, STX, 12, 32'hD0, 0, 0, 0, "R6");
    // R6: store to another word of the line cancels it
    issue(2, LDX, 12, 0, 1, 32'hD0, 0, "R3");
    issue(0, ST, 14, 32'hE4, 0, 0, 0, "R6");
    issue(2, STX, 12, 32'hD1, 0, 0, 1, "R6");
    issue(1, LD, 12, 0, 1, 32'hD0, 0, "R6");
    // R7: event clear, same data still fails
    issue(3, LDX, 20, 0, 1, 32'hB0, 0, "R3");
    rsv_clear[3] = 1'b1;
    @(negedge clk);
    rsv_clear[3] = 1'b0;
    issue(3, STX, 20, 32'hB0, 0, 0, 1, "R7");
    // R10: replacement
    issue(1, ST, 24, 32'h24, 0, 0, 0, "R10");
    issue(1, ST, 28, 32'h28, 0, 0, 0, "R10");
    issue(1, LDX, 24, 0, 1, 32'h24, 0, "R10");
    issue(1, LDX, 28, 0, 1, 32'h28, 0, "R10");
    issue(1, STX, 24, 32'h99, 0, 0, 1, "R10");
    issue(1, LDX, 28, 0, 1, 32'h28, 0, "R10");
    issue(1, STX, 28, 32'h9A, 0, 0, 0, "R10");
    issue(0, LD, 24, 0, 1, 32'h24, 0, "R10");
    // R9: winner clears the other requester
    issue(0, LDX, 32, 0, 0, 0, 0, "R9");
    issue(2, LDX, 33, 0, 0, 0, 0, "R9");
    issue(0, STX, 34, 32'h34, 0, 0, 0, "R9");
    issue(2, STX, 33, 32'h33, 0, 0, 1, "R9");
    issue(3, LD, 34, 0, 1, 32'h34, 0, "R9");
    // R11: clear in the same cycle as store-exclusive / load-exclusive
    issue(1, LDX, 40, 0, 0, 0, 0, "R11");
    issue(1, STX, 40, 32'h40, 0, 0, 1, "R11", 1);
    issue(2, LDX, 44, 0, 0, 0, 0, "R11", 1);
    issue(2, STX, 44, 32'h44, 0, 0, 0, "R11");
    // R12: own store keeps own reservation
    issue(3, LDX, 48, 0, 0, 0, 0, "R12");
    issue(3, ST, 49, 32'h49, 0, 0, 0, "R12");
    issue(3, STX, 48, 32'h48, 0, 0, 0, "R12");
    issue(0, LD, 48, 0, 1, 32'h48, 0, "R12");
    // R2: two requesters at once
    begin
      exp_t e;
      set_req(2, LD, 12, 0);
      set_req(0, LD, 8, 0);
      #1;
      check(grant == 4'b0001, "R2", "grant with r0,r2", 32'(grant), 32'h1);
      e.id = 0; e.chk_data = 1; e.data = 32'hA0; e.status = 0; e.tag = "R2";
      exp_q.push_back(e);
      @(negedge clk);
      req_valid[0] = 1'b0;
      #1;
      check(grant == 4'b0100, "R2", "grant with r2", 32'(grant), 32'h4);
      e.id = 2; e.chk_data = 1; e.data = 32'hD0; e.status = 0; e.tag = "R2";
      exp_q.push_back(e);
      @(negedge clk);
      req_valid[2] = 1'b0;
    end
    // R1: reset drops reservations
    issue(0, LDX, 52, 0, 0, 0, 0, "R1");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(resp_valid == 1'b0, "R1", "resp_valid in second reset", 32'(resp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(0, STX, 52, 32'h52, 0, 0, 1, "R1");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "responses outstanding", 32'(exp_q.size()), 0);
    report();
  end
endmodule